// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

The block is the receive side of a DMA engine. Frame bytes arrive on a byte stream. The engine places each frame into host memory buffers. Each buffer is described by a four-word descriptor, and the descriptors form a ring in memory. Before a descriptor is used, the engine reads it to learn whether the host has handed it over, how large its buffer is, where the buffer is and which descriptor comes next. When a buffer is full or the frame ends, the engine writes a completion status back into the descriptor's first word and hands the descriptor back to the host.

Host software fills the ring, sets the ownership bit in every descriptor it offers, and raises `rx_enable`. When the engine meets a descriptor that the host still holds, it suspends. While suspended it keeps draining the stream, discards the bytes and counts the lost frames. A one-cycle `poll_demand` pulse tells it to look at the same descriptor again.

Both data interfaces use valid/ready. On the byte stream, a byte transfers on a cycle where `s_valid` and `s_ready` are both high. The source must hold `s_valid`, `s_data`, `s_last` and `s_err` steady until that cycle. On the memory port, the engine holds `mem_valid` and every request field steady until `mem_ready` is seen. It has at most one read outstanding, and read data returns on a later cycle marked by `mem_rvalid`.

Top module: `rxd_ring_writer`

## Requirements
- R1: The engine reads descriptor word 0 first. Bit 31 set means the engine owns the descriptor. If bit 31 is clear, the engine suspends and makes no other access for that descriptor.
- R2: Word 1 bits 10:0 give the buffer capacity in bytes, and word 2 gives the buffer byte address. Frame bytes are written in arrival order to buffer address plus offset, one write per byte. Each byte write has the strobe bit selected by address bits 1:0, and the data byte is repeated in all four lanes. No descriptor receives more bytes than its capacity.
- R3: If a frame still has bytes when its buffer is full, the engine writes back the filled descriptor and the frame continues in the next descriptor. That writeback has bit 31 = 0, bit 8 = 0, bits 29:16 = 0 and bit 15 = 0. Bit 30 is 1 only if this was the frame's first descriptor.
- R4: The descriptor that takes a frame's final byte is written back with a full-word write (strobe 4'hF) to its word-0 address. In that write, bit 31 = 0, bit 8 = 1, and bit 30 = 1 only if the frame began in this descriptor. Bits 29:16 hold the total frame byte count, FCS included. Bit 15 holds `s_err` as presented with the last byte.
- R5: After a descriptor whose word 1 bit 25 is set, the next descriptor is at `ring_base`. Otherwise the next descriptor is at the address held in word 3.
- R6: While suspended, the engine accepts stream bytes and discards them. `missed_count` increases by one for each discarded frame, at its last byte, and saturates. The rest of a frame cut off by an unowned descriptor counts as one missed frame.
- R7: A `poll_demand` pulse during suspension makes the engine read word 0 of the same descriptor again, once any frame being discarded has ended. If the host has returned the descriptor, reception resumes. Otherwise the engine suspends again.
- R8: While `rx_enable` is low and no frame is in progress, `s_ready` stays low and no new frame starts. A frame already in progress completes.
- R9: A memory request holds its address, data, strobe and direction until `mem_ready` is seen. A new read is issued only after the previous read's `mem_rvalid`.
- R10: After reset, `s_ready` = 0, `mem_valid` = 0 and `missed_count` = 0, and the first descriptor fetched is the one at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Run bit; reception starts new frames only while high |
| poll_demand | input | 1 | One-cycle pulse asking a suspended engine to re-read its descriptor |
| ring_base | input | AW | Byte address of the first descriptor in the ring |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted this cycle when high with s_valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_err | input | 1 | Frame error flag, read with the final byte |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| missed_count | output | MISS_W | Count of frames discarded while suspended |

## Verification
A byte write request appears on the cycle after the byte is taken from the stream. The writeback request appears on the cycle after the last byte's write (or the overflowing byte's arrival) is accepted. A descriptor fetch costs one request and one response cycle per word, with `mem_ready` held low on some cycles to stretch it. The bench keeps an ordered queue of expected memory writes, built from the descriptor ring it set up, and compares every write on the cycle of its handshake, so the result does not depend on the exact stall pattern. `s_ready` is sampled just before the clock edge. `missed_count` is compared only after a drain window longer than any fetch-and-writeback sequence.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_RREQ, ST_RWAIT, ST_RECV, ST_WBYTE, ST_WBACK, ST_SUSP
  } rxd_state_e;

  // descriptor word 0 (status) bit positions, decoded by host software
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 30;
  localparam int LEN_LSB   = 16;
  localparam int ERR_BIT   = 15;
  localparam int LAST_BIT  = 8;
  // descriptor word 1 control bit
  localparam int EOR_BIT   = 25;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] ring_base,
  input  logic [AW-1:0] link_ptr,
  output logic [AW-1:0] cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur <= '0;
    else if (load_base) cur <= ring_base;
    else if (advance)   cur <= wrap ? ring_base : link_ptr;
  end
endmodule

// File: rtl/rxd_status_pack.sv
module rxd_status_pack #(
  parameter int LEN_W = 14
) (
  input  logic             first,
  input  logic             last,
  input  logic             err,
  input  logic [LEN_W-1:0] len,
  output logic [31:0]      word
);
  import rxd_pkg::*;
  always_comb begin
    word                     = '0;
    word[FIRST_BIT]          = first;
    word[LAST_BIT]           = last;
    word[ERR_BIT]            = last & err;
    word[LEN_LSB +: LEN_W]   = last ? len : '0;
  end
endmodule

// File: rtl/rxd_miss_ctr.sv
module rxd_miss_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = '1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (bump && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
  import rxd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 11,
  parameter int LEN_W  = 14,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              poll_demand,
  input  logic [AW-1:0]     ring_base,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic              s_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] missed_count
);
  localparam int WORD_SEL_W = 2;

  rxd_state_e            st;
  logic [WORD_SEL_W-1:0] widx;
  logic [AW-1:0]         cur, link_ptr, buf_base, byte_addr;
  logic [SIZE_W-1:0]     cap, off;
  logic [LEN_W-1:0]      flen;
  logic                  eor, first_q, in_frame, drop_mid, poll_pend;
  logic                  hold_last, hold_err, wb_final;
  logic [7:0]            hold_byte;
  logic [31:0]           status_word;
  logic                  room, may_take, take, spill, advance, bump;

  assign room      = (off != cap);
  assign may_take  = in_frame | rx_enable;
  assign byte_addr = buf_base + AW'(off);

  always_comb begin
    s_ready = 1'b0;
    case (st)
      ST_RECV: s_ready = may_take & room;
      ST_SUSP: s_ready = 1'b1;
      default: s_ready = 1'b0;
    endcase
  end

  assign take    = s_valid & s_ready;
  assign spill   = (st == ST_RECV) & s_valid & may_take & ~room;
  assign advance = (st == ST_WBACK) & mem_ready;
  assign bump    = (st == ST_SUSP) & take & s_last;

  rxd_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_base(st == ST_INIT), .advance(advance),
    .wrap(eor), .ring_base(ring_base), .link_ptr(link_ptr), .cur(cur)
  );

  rxd_status_pack #(.LEN_W(LEN_W)) u_pack (
    .first(first_q), .last(wb_final), .err(hold_err), .len(flen), .word(status_word)
  );

  rxd_miss_ctr #(.CW(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .bump(bump), .count(missed_count)
  );

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    mem_wstrb = '0;
    case (st)
      ST_RREQ: begin
        mem_valid = 1'b1;
        mem_addr  = cur + AW'({widx, 2'b00});
      end
      ST_WBYTE: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = byte_addr;
        mem_wdata = {4{hold_byte}};
        mem_wstrb = 4'b0001 << byte_addr[1:0];
      end
      ST_WBACK: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_wdata = status_word;
        mem_wstrb = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      widx      <= '0;
      link_ptr  <= '0;
      buf_base  <= '0;
      cap       <= '0;
      off       <= '0;
      flen      <= '0;
      eor       <= 1'b0;
      first_q   <= 1'b1;
      in_frame  <= 1'b0;
      drop_mid  <= 1'b0;
      poll_pend <= 1'b0;
      hold_last <= 1'b0;
      hold_err  <= 1'b0;
      hold_byte <= '0;
      wb_final  <= 1'b0;
    end else begin
      case (st)
        ST_INIT: st <= ST_IDLE;
        ST_IDLE: if (rx_enable) begin
          widx <= '0;
          st   <= ST_RREQ;
        end
        ST_RREQ: if (mem_ready) st <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid) begin
          widx <= widx + 1'b1;
          st   <= ST_RREQ;
          case (widx)
            2'd0: if (!mem_rdata[OWN_BIT]) begin
              st        <= ST_SUSP;
              drop_mid  <= in_frame;
              poll_pend <= 1'b0;
            end
            2'd1: begin
              cap <= mem_rdata[SIZE_W-1:0];
              eor <= mem_rdata[EOR_BIT];
            end
            2'd2: buf_base <= mem_rdata[AW-1:0];
            default: begin
              link_ptr <= mem_rdata[AW-1:0];
              off      <= '0;
              st       <= ST_RECV;
            end
          endcase
        end
        ST_RECV: begin
          if (take) begin
            hold_byte <= s_data;
            hold_last <= s_last;
            hold_err  <= s_err;
            in_frame  <= 1'b1;
            st        <= ST_WBYTE;
          end else if (spill) begin
            in_frame <= 1'b1;
            wb_final <= 1'b0;
            st       <= ST_WBACK;
          end
        end
        ST_WBYTE: if (mem_ready) begin
          off  <= off + 1'b1;
          flen <= flen + 1'b1;
          if (hold_last) begin
            wb_final <= 1'b1;
            st       <= ST_WBACK;
          end else begin
            st <= ST_RECV;
          end
        end
        ST_WBACK: if (mem_ready) begin
          widx <= '0;
          if (wb_final) begin
            first_q  <= 1'b1;
            in_frame <= 1'b0;
            flen     <= '0;
            wb_final <= 1'b0;
            st       <= ST_IDLE;
          end else begin
            first_q <= 1'b0;
            st      <= ST_RREQ;
          end
        end
        ST_SUSP: begin
          if (poll_demand) poll_pend <= 1'b1;
          if (take) drop_mid <= ~s_last;
          if ((poll_pend | poll_demand) && !drop_mid && !take) begin
            st        <= ST_RREQ;
            widx      <= '0;
            poll_pend <= 1'b0;
            in_frame  <= 1'b0;
            flen      <= '0;
            first_q   <= 1'b1;
          end
        end
        default: st <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk #(
  parameter int AW     = 32,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [AW-1:0]     mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_wstrb,
  input logic              mem_rvalid,
  input logic [MISS_W-1:0] missed_count
);
  logic rd_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       rd_open <= 1'b0;
    else if (mem_valid && mem_ready && !mem_write)    rd_open <= 1'b1;
    else if (mem_rvalid)                              rd_open <= 1'b0;
  end

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_wdata) && $stable(mem_wstrb));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open && !mem_rvalid |-> !(mem_valid && !mem_write));

  a_r4_owner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && mem_wstrb == 4'hF |-> !mem_wdata[31]);

  a_r3_partial_clean: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && mem_wstrb == 4'hF && !mem_wdata[8]
      |-> mem_wdata[29:16] == 14'd0 && !mem_wdata[15]);

  a_r4_final_len: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && mem_wstrb == 4'hF && mem_wdata[8] |-> mem_wdata[29:16] != 14'd0);

  a_r2_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && mem_wstrb != 4'hF
      |-> $countones(mem_wstrb) == 1 && mem_wstrb[mem_addr[1:0]]);

  a_r6_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, missed_count} == {1'b0, $past(missed_count)}
              || {1'b0, missed_count} == {1'b0, $past(missed_count)} + 1'b1));
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.AW(AW), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_wstrb(mem_wstrb), .mem_rvalid(mem_rvalid), .missed_count(missed_count)
);

// File: tb/sim_rxd_ring_writer.sv
module sim_rxd_ring_writer;
  localparam int AW = 32;
  localparam int MISS_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0, rx_enable = 1'b0, poll_demand = 1'b0;
  logic [AW-1:0]     ring_base = 32'h100;
  logic              s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0, s_ready;
  logic [7:0]        s_data = 8'h00;
  logic              mem_valid, mem_write, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0]     mem_addr;
  logic [31:0]       mem_wdata, mem_rdata = 32'h0;
  logic [3:0]        mem_wstrb;
  logic [MISS_W-1:0] missed_count;

  rxd_ring_writer #(.AW(AW), .MISS_W(MISS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .poll_demand(poll_demand),
    .ring_base(ring_base), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_err(s_err), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .missed_count(missed_count)
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mem [0:4095];

  // expected memory writes, in issue order
  logic [31:0] eq_addr[$];
  logic [31:0] eq_data[$];
  logic [3:0]  eq_strb[$];
  string       eq_tag[$];

  // ring model
  logic [31:0] d_addr[3], d_buf[3];
  int          d_cap[3];
  bit          d_own[3], d_eor[3];
  int          mi = 0, exp_missed = 0;
  bit          m_susp = 1'b0, m_via_eor = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int p);
    return 8'((seed * 37 + p * 11 + 5) & 255);
  endfunction

  function automatic void push_wr(logic [31:0] a, logic [31:0] d, logic [3:0] s, string t);
    eq_addr.push_back(a); eq_data.push_back(d); eq_strb.push_back(s); eq_tag.push_back(t);
  endfunction

  function automatic void m_advance();
    m_via_eor = d_eor[mi];
    mi = d_eor[mi] ? 0 : mi + 1;
    if (!d_own[mi]) m_susp = 1'b1;
  endfunction

  function automatic void model_frame(int len, bit err, int seed);
    int  off = 0, pos = 0;
    bit  first = 1'b1;
    logic [31:0] a, st;
    if (m_susp) begin exp_missed++; return; end
    while (pos < len) begin
      if (off == d_cap[mi]) begin
        st = 32'h0; st[30] = first;
        push_wr(d_addr[mi], st, 4'hF, m_via_eor ? "R5/R3 partial writeback" : "R3 partial writeback");
        d_own[mi] = 1'b0; first = 1'b0; off = 0;
        m_advance();
        if (m_susp) begin exp_missed++; return; end
      end else begin
        a = d_buf[mi] + off;
        push_wr(a, {4{pat(seed, pos)}}, 4'b0001 << a[1:0], m_via_eor ? "R5/R2 byte write" : "R2 byte write");
        off++; pos++;
      end
    end
    st = 32'h0; st[30] = first; st[29:16] = 14'(len); st[15] = err; st[8] = 1'b1;
    push_wr(d_addr[mi], st, 4'hF, m_via_eor ? "R5/R4 final writeback" : "R4 final writeback");
    d_own[mi] = 1'b0;
    m_advance();
  endfunction

  // memory responder and per-cycle write comparison
  bit          rd_pend = 1'b0, prev_stall = 1'b0;
  logic [11:0] rd_idx = '0;
  logic [31:0] prev_addr = '0;
  int          cyc = 0;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (rd_pend) begin mem_rvalid = 1'b1; mem_rdata = mem[rd_idx]; rd_pend = 1'b0; end
    cyc++;
    mem_ready = (cyc % 3) != 0;
    #1;
    if (rst_n) begin
      if (prev_stall) begin
        chk("R9 request held under back-pressure (valid)", 32'(mem_valid), 32'd1);
        chk("R9 request held under back-pressure (addr)", mem_addr, prev_addr);
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          if (eq_addr.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 unexpected write: actual addr %h data %h expected none", mem_addr, mem_wdata);
          end else begin
            chk({eq_tag[0], " addr"}, mem_addr, eq_addr[0]);
            chk({eq_tag[0], " data"}, mem_wdata, eq_data[0]);
            chk({eq_tag[0], " strobe"}, 32'(mem_wstrb), 32'(eq_strb[0]));
            void'(eq_addr.pop_front()); void'(eq_data.pop_front());
            void'(eq_strb.pop_front()); void'(eq_tag.pop_front());
          end
          for (int b = 0; b < 4; b++)
            if (mem_wstrb[b]) mem[mem_addr[13:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        end else begin
          rd_pend = 1'b1;
          rd_idx  = mem_addr[13:2];
        end
      end
    end
  end

  task automatic drain();
    repeat (45) @(negedge clk);
  endtask

  task automatic wait_accept();
    bit got;
    do begin
      #1; got = s_ready;
      @(negedge clk);
    end while (!got);
  endtask

  task automatic send_frame(int len, bit err, int seed);
    model_frame(len, err, seed);
    for (int p = 0; p < len; p++) begin
      s_valid = 1'b1; s_data = pat(seed, p);
      s_last = (p == len - 1); s_err = err && (p == len - 1);
      wait_accept();
    end
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    drain();
    chk("R6 missed frame count", 32'(missed_count), 32'(exp_missed));
  endtask

  task automatic give_back(int i);
    mem[d_addr[i] >> 2] = 32'h8000_0000;
    d_own[i] = 1'b1;
  endtask

  task automatic poll();
    poll_demand = 1'b1;
    if (m_susp && d_own[mi]) m_susp = 1'b0;
    @(negedge clk);
    poll_demand = 1'b0;
    drain();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    d_cap[0] = 64; d_cap[1] = 6; d_cap[2] = 64;
    for (int i = 0; i < 3; i++) begin
      d_addr[i] = 32'h100 + 32'(16 * i);
      d_buf[i]  = 32'h1000 + 32'(32'h400 * i) + ((i == 1) ? 32'd2 : 32'd0);
      d_eor[i]  = (i == 2);
      d_own[i]  = 1'b1;
      mem[(d_addr[i] >> 2) + 0] = 32'h8000_0000;
      mem[(d_addr[i] >> 2) + 1] = 32'(d_cap[i]) | (d_eor[i] ? 32'h0200_0000 : 32'h0);
      mem[(d_addr[i] >> 2) + 2] = d_buf[i];
      mem[(d_addr[i] >> 2) + 3] = (i < 2) ? d_addr[i] + 32'd16 : 32'h500;
    end

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 s_ready in reset", 32'(s_ready), 32'd0);
    chk("R10 mem_valid in reset", 32'(mem_valid), 32'd0);
    chk("R10 missed_count in reset", 32'(missed_count), 32'd0);
    rst_n = 1'b1;

    // R8: run bit low, frame offered, nothing happens
    s_valid = 1'b1; s_data = pat(1, 0); s_last = 1'b0;
    repeat (10) begin
      @(negedge clk); #1;
      chk("R8 s_ready low while disabled", 32'(s_ready), 32'd0);
      chk("R8 no memory access while disabled", 32'(mem_valid), 32'd0);
    end
    @(negedge clk);
    rx_enable = 1'b1;
    send_frame(10, 1'b0, 1);           // A: fits in first descriptor (R10 base, R2, R4)

    // R8: disabled between frames, prefetched descriptor still idle
    rx_enable = 1'b0;
    drain();
    s_valid = 1'b1; s_data = pat(2, 0); s_last = 1'b0;
    repeat (8) begin
      @(negedge clk); #1;
      chk("R8 no new frame while disabled", 32'(s_ready), 32'd0);
    end
    @(negedge clk);
    rx_enable = 1'b1;
    send_frame(14, 1'b1, 2);           // B: spills 6 + 8, error flagged (R3, R4)

    // R1: ring wrapped to an unowned descriptor, engine suspended
    #1;
    chk("R1 suspended engine drains stream", 32'(s_ready), 32'd1);
    @(negedge clk);
    send_frame(5, 1'b0, 3);            // C dropped (R6)
    send_frame(3, 1'b1, 4);            // D dropped (R6)

    give_back(0); give_back(1);
    poll();                            // R7: resume at ring_base (R5)
    send_frame(20, 1'b0, 5);           // E into descriptor 0
    send_frame(10, 1'b0, 6);           // F: 6 bytes, then unowned -> remainder dropped

    poll();                            // still unowned: stays suspended
    send_frame(7, 1'b0, 7);            // G dropped
    chk("R7 poll on unowned descriptor keeps suspension", 32'(missed_count), 32'd4);

    give_back(2);
    poll();
    send_frame(4, 1'b0, 8);            // H: single-descriptor frame in last entry

    chk("R4 all expected writes issued", 32'(eq_addr.size()), 32'd0);
    chk("R4 descriptor 2 status in memory", mem[d_addr[2] >> 2], 32'h4004_0100);
    summary();
    $finish;
  end
endmodule